// File: doc/BRIEF.md
# Byte-Verify Pulse Programming Controller

This block is a sequencer that writes a parallel, UV-erasable programmable memory one byte at a time. It asks the host for the byte that belongs at each address, raises the programming supply requests, and fires a timed chip-enable low pulse. It then reads the byte back with the outputs enabled and the chip deselected. A byte that does not read back correctly gets another pulse. A byte that is still wrong after the retry limit ends the run as a failure.

Addresses are walked upward from zero to the last location. When every byte has verified, both supply requests drop to the normal read level. The controller then reads the whole array once more in normal read mode and compares each byte with the host data. At the end of a run it raises either a pass flag or a fail flag. On a fail it also reports the address that caused it.

All durations (pulse width, setup, hold, read access) are given in nanoseconds and turned into clock-cycle counts from the clock frequency parameter.

Top module: `eprom_pulse_prog`

## Requirements
- R1: After reset and whenever the controller is not busy, ce_no and oe_no are high, vpp_hi_o and vcc_hi_o are low, dq_oe_o is low, busy_o is low, and pass_o and fail_o are low until the first run completes.
- R2: Each program pulse holds ce_no low for exactly PULSE_NS converted to cycles (200 cycles with the bench parameters, that is 100 µs, inside the 95–105 µs window). Throughout the pulse, oe_no is high, dq_oe_o is high and both supply requests are high.
- R3: Address, data, oe_no, dq_oe_o and both supply requests are unchanged for at least SETUP_NS in cycles before ce_no falls for a pulse. Data stays driven and unchanged for at least HOLD_NS in cycles after ce_no rises.
- R4: After each pulse the byte is read back with ce_no high, oe_no low, both supply requests high and dq_oe_o low (bus released).
- R5: A byte that mismatches on read-back is pulsed again. Each address receives exactly as many pulses as it takes for its read-back to match.
- R6: If a byte still mismatches after MAX_PULSES (10) pulses, the run ends with fail_o high and fail_addr_o equal to that address. No further pulses are applied.
- R7: Addresses are programmed in ascending order from 0 to 2^ADDR_W-1. addr_o only ever steps by +1 or returns to 0.
- R8: After the last address verifies, a final pass reads every address with ce_no low, oe_no low and both supply requests low. The first byte that differs from src_data_i ends the run with fail_o high and fail_addr_o equal to its address.
- R9: busy_o is high from the cycle after start_i until the run ends. pass_o goes high when every byte has verified and the final compare has matched everywhere.
- R10: A start_i pulse while busy_o is high has no effect on the sequence in progress.
- R11: Accepting start_i clears pass_o and fail_o. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a programming run (used only while idle) |
| busy_o | output | 1 | Run in progress |
| pass_o | output | 1 | Last run completed successfully |
| fail_o | output | 1 | Last run failed |
| fail_addr_o | output | ADDR_W | Address at which the last run failed |
| addr_o | output | ADDR_W | Memory address; also selects the host data byte |
| src_data_i | input | DATA_W | Intended byte for addr_o, from the host |
| dq_o | output | DATA_W | Data driven to the memory bus |
| dq_oe_o | output | 1 | Drive enable for dq_o (low releases the bus) |
| dq_i | input | DATA_W | Data read from the memory bus |
| ce_no | output | 1 | Active-low chip enable / program pulse |
| oe_no | output | 1 | Active-low output enable |
| vpp_hi_o | output | 1 | Request for the high programming supply |
| vcc_hi_o | output | 1 | Request for the raised core supply |

## Verification
The bench builds the controller with CLK_HZ = 2 MHz and ADDR_W = 3. This gives 8 locations, a 200-cycle pulse and 4-cycle setup and hold. A whole run with every retry up to the 10-pulse limit therefore fits in a few thousand cycles. A behavioural memory model needs a chosen number of pulses per address before a byte sticks. This makes it possible to test an address that passes on exactly the tenth pulse, one that needs an eleventh, a bit that cannot be programmed back high, and a byte that reads wrong only at normal supply levels. The model also measures pulse width, setup and hold on every pulse at the pins.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_VFY,
    ST_NSET,
    ST_FREAD
  } ppc_state_e;

  // ceiling conversion of a duration to clock cycles, never less than one
  function automatic int unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
    longint unsigned c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c[31:0];
  endfunction

endpackage

// File: rtl/ppc_timer.sv
module ppc_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/ppc_addr_cnt.sv
module ppc_addr_cnt #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (inc_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = &addr_q;

endmodule

// File: rtl/ppc_retry_cnt.sv
module ppc_retry_cnt #(
  parameter int unsigned MAX_PULSES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_max_o
);

  localparam int unsigned RW = $clog2(MAX_PULSES + 1);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && !at_max_o)     cnt_q <= cnt_q + 1'b1;
  end

  assign at_max_o = (cnt_q == RW'(MAX_PULSES));

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RW'(MAX_PULSES));

endmodule

// File: rtl/eprom_pulse_prog.sv
module eprom_pulse_prog #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned MAX_PULSES = 10,
  parameter int unsigned PULSE_NS   = 100_000,
  parameter int unsigned SETUP_NS   = 2_000,
  parameter int unsigned HOLD_NS    = 2_000,
  parameter int unsigned ACCESS_NS  = 300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i,
  output logic              ce_no,
  output logic              oe_no,
  output logic              vpp_hi_o,
  output logic              vcc_hi_o
);
  import ppc_pkg::*;

  localparam int unsigned PULSE_CYC = ns_to_cyc(CLK_HZ, PULSE_NS);
  localparam int unsigned SETUP_CYC = ns_to_cyc(CLK_HZ, SETUP_NS);
  localparam int unsigned HOLD_CYC  = ns_to_cyc(CLK_HZ, HOLD_NS);
  localparam int unsigned RD_CYC    = ns_to_cyc(CLK_HZ, ACCESS_NS) + 1;
  localparam int unsigned MAX_A     = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int unsigned MAX_B     = (HOLD_CYC > RD_CYC) ? HOLD_CYC : RD_CYC;
  localparam int unsigned MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW        = $clog2(MAX_CYC + 1);

  localparam logic [TW-1:0] T_PULSE = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] T_SETUP = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] T_HOLD  = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] T_RD    = TW'(RD_CYC - 1);

  ppc_state_e state_q, state_d;

  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          addr_clr, addr_inc, addr_last;
  logic          rty_clr, rty_inc, rty_max;
  logic          set_pass, set_fail, clr_flags;
  logic          rd_match;
  logic          pass_q, fail_q;
  logic [ADDR_W-1:0] fail_addr_q;

  ppc_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  ppc_addr_cnt #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (addr_clr),
    .inc_i  (addr_inc),
    .addr_o (addr_o),
    .last_o (addr_last)
  );

  ppc_retry_cnt #(.MAX_PULSES(MAX_PULSES)) u_retry (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rty_clr),
    .inc_i    (rty_inc),
    .at_max_o (rty_max)
  );

  assign rd_match = (dq_i == src_data_i);

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    addr_clr  = 1'b0;
    addr_inc  = 1'b0;
    rty_clr   = 1'b0;
    rty_inc   = 1'b0;
    set_pass  = 1'b0;
    set_fail  = 1'b0;
    clr_flags = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d   = ST_SETUP;
        tmr_load  = 1'b1;
        tmr_val   = T_SETUP;
        addr_clr  = 1'b1;
        rty_clr   = 1'b1;
        clr_flags = 1'b1;
      end
      ST_SETUP: if (tmr_done) begin
        state_d  = ST_PULSE;
        tmr_load = 1'b1;
        tmr_val  = T_PULSE;
        rty_inc  = 1'b1;
      end
      ST_PULSE: if (tmr_done) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = T_HOLD;
      end
      ST_HOLD: if (tmr_done) begin
        state_d  = ST_VFY;
        tmr_load = 1'b1;
        tmr_val  = T_RD;
      end
      ST_VFY: if (tmr_done) begin
        if (rd_match) begin
          tmr_load = 1'b1;
          tmr_val  = T_SETUP;
          rty_clr  = 1'b1;
          if (addr_last) begin
            state_d  = ST_NSET;
            addr_clr = 1'b1;
          end else begin
            state_d  = ST_SETUP;
            addr_inc = 1'b1;
          end
        end else if (rty_max) begin
          state_d  = ST_IDLE;
          set_fail = 1'b1;
        end else begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = T_SETUP;
        end
      end
      ST_NSET: if (tmr_done) begin
        state_d  = ST_FREAD;
        tmr_load = 1'b1;
        tmr_val  = T_RD;
      end
      ST_FREAD: if (tmr_done) begin
        if (!rd_match) begin
          state_d  = ST_IDLE;
          set_fail = 1'b1;
        end else if (addr_last) begin
          state_d  = ST_IDLE;
          set_pass = 1'b1;
        end else begin
          addr_inc = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = T_RD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (clr_flags) begin
        pass_q <= 1'b0;
        fail_q <= 1'b0;
      end
      if (set_pass) pass_q <= 1'b1;
      if (set_fail) begin
        fail_q      <= 1'b1;
        fail_addr_q <= addr_o;
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;
  assign dq_o        = src_data_i;
  assign dq_oe_o     = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign ce_no       = !((state_q == ST_PULSE) || (state_q == ST_FREAD));
  assign oe_no       = !((state_q == ST_VFY) || (state_q == ST_FREAD));
  assign vpp_hi_o    = dq_oe_o || (state_q == ST_VFY);
  assign vcc_hi_o    = vpp_hi_o;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ce_no && oe_no && !vpp_hi_o && !vcc_hi_o && !dq_oe_o));

  // R2
  pulse_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_no && vpp_hi_o) |-> (oe_no && dq_oe_o && vcc_hi_o));

  // R3
  setup_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ce_no) && vpp_hi_o) |->
      ($stable(addr_o) && $stable(dq_o) && $stable(oe_no) && $stable(vpp_hi_o) && $stable(dq_oe_o)));

  // R4
  vfy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> !dq_oe_o);

  // R7
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_o) |-> (addr_o == '0 || addr_o == ADDR_W'($past(addr_o) + 1'b1)));

  // R8
  final_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_no && !oe_no) |-> (!vpp_hi_o && !vcc_hi_o));

  // R11
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));

endmodule

// File: tb/sim_eprom_pulse_prog.sv
module sim_eprom_pulse_prog;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int N  = 1 << AW;
  localparam int PULSE_C = 200;
  localparam int SETUP_C = 4;
  localparam int HOLD_C  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, pass, fail, dq_oe, ce_n, oe_n, vpp_hi, vcc_hi;
  logic [AW-1:0] fail_addr, addr;
  logic [7:0] src_data, dq_o, dq_i;

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory and host models
  logic [7:0] mem [N];
  logic [7:0] src [N];
  int need [N];
  int pcount [N];
  int order_q [$];
  int flip_addr = -1;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int wid = 0, wmin = 1 << 30, wmax = 0;
  int setup_viol = 0, hold_viol = 0, tri_viol = 0;
  int stab = 0, hold_left = 0;
  logic [7:0] hold_data;
  logic prev_ce = 1'b1, prev_busy = 1'b0;
  logic [AW+12-1:0] prev_sig = '0;

  typedef struct { bit ok; int addr; } exp_t;
  exp_t exp_q [$];

  assign src_data = src[addr];
  assign dq_i = (!oe_n && ce_n && vpp_hi) ? mem[addr] :
                (!oe_n && !ce_n && !vpp_hi) ? (mem[addr] ^ ((int'(addr) == flip_addr) ? 8'h01 : 8'h00)) :
                8'h00;

  eprom_pulse_prog #(
    .CLK_HZ (2_000_000),
    .ADDR_W (AW)
  ) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .busy_o      (busy),
    .pass_o      (pass),
    .fail_o      (fail),
    .fail_addr_o (fail_addr),
    .addr_o      (addr),
    .src_data_i  (src_data),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe),
    .dq_i        (dq_i),
    .ce_no       (ce_n),
    .oe_no       (oe_n),
    .vpp_hi_o    (vpp_hi),
    .vcc_hi_o    (vcc_hi)
  );

  task automatic check(input bit cond, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, expv);
    end
  endtask

  // model and monitor, sampled mid-cycle
  always @(negedge clk) begin
    logic [AW+12-1:0] sig;
    sig = {addr, dq_o, dq_oe, oe_n, vpp_hi, vcc_hi};
    if (sig == prev_sig) stab++; else stab = 0;
    prev_sig = sig;
    if (rst_n) begin
      if (!oe_n && dq_oe) tri_viol++;
      if (prev_ce && !ce_n && vpp_hi && stab < SETUP_C) setup_viol++;
      if (!prev_ce && ce_n && vpp_hi) begin
        if (wid < wmin) wmin = wid;
        if (wid > wmax) wmax = wid;
        wid = 0;
        pcount[addr]++;
        if (pcount[addr] == 1) order_q.push_back(int'(addr));
        if (pcount[addr] == need[addr]) mem[addr] = mem[addr] & dq_o;
        hold_left = HOLD_C;
        hold_data = dq_o;
      end
      if (hold_left > 0) begin
        if (!dq_oe || dq_o != hold_data) hold_viol++;
        hold_left--;
      end
      if (!ce_n && vpp_hi) wid++;
      if (prev_busy && !busy) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected completion", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check(pass == e.ok, e.ok ? "R9" : "R6", "pass_o", int'(pass), int'(e.ok));
          check(fail == !e.ok, e.ok ? "R9" : "R6", "fail_o", int'(fail), int'(!e.ok));
          if (!e.ok) check(int'(fail_addr) == e.addr, "R8", "fail_addr_o", int'(fail_addr), e.addr);
        end
        done_cnt++;
      end
    end
    prev_ce = ce_n;
    prev_busy = busy;
  end

  task automatic erase();
    for (int i = 0; i < N; i++) begin
      mem[i] = 8'hFF;
      pcount[i] = 0;
      need[i] = 1;
    end
    order_q.delete();
    flip_addr = -1;
    wmin = 1 << 30; wmax = 0;
    setup_viol = 0; hold_viol = 0; tri_viol = 0;
  endtask

  task automatic run(input bit ok, input int faddr, input bit double_start);
    int t;
    exp_t e;
    e.ok = ok; e.addr = faddr;
    exp_q.push_back(e);
    t = done_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R11: flags cleared once start is taken
    check(!pass && !fail, "R11", "flags after start", int'(pass) + 2 * int'(fail), 0);
    check(busy == 1'b1, "R9", "busy_o during run", int'(busy), 1);
    if (double_start) begin
      repeat (50) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    wait (done_cnt != t);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_timing(input string tag);
    if (wmax > 0) begin
      check(wmin == PULSE_C && wmax == PULSE_C, "R2", {tag, " pulse width"}, wmax, PULSE_C);
    end
    check(setup_viol == 0, "R3", {tag, " setup violations"}, setup_viol, 0);
    check(hold_viol == 0, "R3", {tag, " hold violations"}, hold_viol, 0);
    check(tri_viol == 0, "R4", {tag, " bus driven during read"}, tri_viol, 0);
  endtask

  task automatic chk_counts(input int expc [N], input string tag);
    for (int i = 0; i < N; i++)
      check(pcount[i] == expc[i], tag, $sformatf("pulses at %0d", i), pcount[i], expc[i]);
  endtask

  initial begin
    int expc [N];
    for (int i = 0; i < N; i++) src[i] = 8'(i * 37) ^ 8'h5A;
    erase();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ce_n && oe_n, "R1", "ce_no/oe_no", int'({ce_n, oe_n}), 3);
    check(!vpp_hi && !vcc_hi && !dq_oe, "R1", "supplies/drive", int'({vpp_hi, vcc_hi, dq_oe}), 0);
    check(!busy && !pass && !fail, "R1", "status", int'({busy, pass, fail}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && ce_n && oe_n, "R1", "idle after reset", int'({busy, ce_n, oe_n}), 3);

    // case A: every byte sticks on the first pulse
    erase();
    run(1'b1, 0, 1'b0);
    for (int i = 0; i < N; i++) expc[i] = 1;
    chk_counts(expc, "R5");
    check(order_q.size() == N, "R7", "addresses visited", order_q.size(), N);
    for (int i = 0; i < order_q.size(); i++)
      check(order_q[i] == i, "R7", "visit order", order_q[i], i);
    for (int i = 0; i < N; i++) check(mem[i] == src[i], "R9", "programmed byte", int'(mem[i]), int'(src[i]));
    chk_timing("A");
    check(!busy && ce_n && oe_n && !vpp_hi, "R1", "idle after pass", int'({busy, ce_n, oe_n, vpp_hi}), 6);

    // case B: varied retries, tenth pulse passes, second start while busy
    erase();
    need = '{1, 3, 2, 10, 1, 5, 1, 2};
    run(1'b1, 0, 1'b1);
    for (int i = 0; i < N; i++) expc[i] = need[i];
    chk_counts(expc, "R10");
    chk_counts(expc, "R5");
    check(exp_q.size() == 0, "R10", "pending completions", exp_q.size(), 0);
    chk_timing("B");

    // case C: a byte needs more than the limit
    erase();
    need[5] = 11;
    run(1'b0, 5, 1'b0);
    for (int i = 0; i < N; i++) expc[i] = (i < 5) ? 1 : (i == 5) ? 10 : 0;
    chk_counts(expc, "R6");
    check(mem[5] == 8'hFF, "R6", "failing byte untouched", int'(mem[5]), 255);
    chk_timing("C");

    // case D: final compare at normal supply detects a byte
    erase();
    flip_addr = 6;
    run(1'b0, 6, 1'b0);
    for (int i = 0; i < N; i++) expc[i] = 1;
    chk_counts(expc, "R8");
    chk_timing("D");

    // case E: a cleared bit cannot be raised by programming
    erase();
    mem[2] = 8'h00;
    src[2] = 8'hFF;
    run(1'b0, 2, 1'b0);
    for (int i = 0; i < N; i++) expc[i] = (i < 2) ? 1 : (i == 2) ? 10 : 0;
    chk_counts(expc, "R6");
    chk_timing("E");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog busy act=%0d exp=0", int'(busy));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule